// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This combinational block sits beside the mantissa datapath of a single-precision fused multiply-add unit computing `z + (x * y)`. It decides whether the answer follows from the operand classes alone and needs no arithmetic: NaN inputs, infinities, and products or sums that are exact zeros. When it can settle the result, it raises a bypass flag and supplies the finished 32-bit word together with the invalid-operation flag. When it cannot, the bypass and invalid flags stay low and the datapath result is used.

Two negate controls turn the same hardware into the four multiply-add variants. One control flips the sign of the product and the other flips the sign of the addend. The block also outputs the resulting effective product and addend signs, which the datapath needs for its add/subtract decision. A 2-bit rounding-mode input has one use: it picks the sign of an exact zero that comes from adding zeros of opposite sign.

Top module: `fma_special_resolve`

## Requirements
- R1: `prod_sign` equals `x[31] ^ y[31] ^ neg_prod` and `add_sign` equals `z[31] ^ neg_add`, for every input.
- R2: A signalling NaN has exponent 8'hFF, a nonzero fraction and fraction bit 22 clear. If any operand is a signalling NaN, the first one in the order z, x, y is returned with bit 22 set, and `byp_valid` and `invalid` are both 1.
- R3: A quiet NaN has exponent 8'hFF and fraction bit 22 set. If no operand is a signalling NaN but some operand is a quiet NaN, the first quiet NaN in the order z, x, y is returned unchanged, with `byp_valid`=1 and `invalid`=0.
- R4: If there is no NaN and one multiplicand is infinite while the other is zero, in either order, the result is 32'h7FC00000 with `invalid`=1.
- R5: If there is no NaN and the product is infinite (neither multiplicand zero), and z is an infinity whose sign differs from `prod_sign`, the result is 32'h7FC00000 with `invalid`=1.
- R6: In every other infinite-product case the result is an infinity (exponent 8'hFF, fraction 0) with sign `prod_sign`, and `invalid`=0.
- R7: If there is no NaN, the product is zero and z is nonzero, the result is z's magnitude bits with sign `add_sign`, and `invalid`=0. This includes a denormal or infinite z.
- R8: If there is no NaN, the product is zero, z is zero and `add_sign` equals `prod_sign`, the result is a zero with sign `add_sign`.
- R9: If there is no NaN, the product is zero, z is zero and the two signs differ, the result is a zero with sign 1 only when `rnd_mode` is 2'b11 (toward minus infinity).
- R10: If there is no NaN, both multiplicands are finite and nonzero (normal or denormal) and z is infinite, the result is an infinity with sign `add_sign`, and `invalid`=0.
- R11: In all remaining cases `byp_valid`=0, `invalid`=0 and `byp_result`=0.
- R12: `invalid` is never 1 while `byp_valid` is 0, and whenever it is 1 the bypass word is a quiet NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_z | input | 32 | Addend operand |
| in_x | input | 32 | First multiplicand |
| in_y | input | 32 | Second multiplicand |
| neg_prod | input | 1 | Invert the product sign |
| neg_add | input | 1 | Invert the addend sign |
| rnd_mode | input | 2 | Rounding mode; 2'b11 means toward minus infinity |
| byp_valid | output | 1 | The result is resolved without arithmetic |
| byp_result | output | 32 | Resolved result word (zero when not bypassing) |
| invalid | output | 1 | Invalid-operation flag |
| prod_sign | output | 1 | Effective sign of the product |
| add_sign | output | 1 | Effective sign of the addend |

## Verification
There are no registers on any path, so every output is due in the same cycle as the inputs that produce it and has no history. The bench drives each stimulus at a falling clock edge and samples 2 ns later, well before the next rising edge. Each check therefore sees only the current operand set. The sweep covers every ordered triple from ten representative operands under all negate-control and rounding-mode combinations, and compares all five outputs against a rule-by-rule model.

// File: rtl/fma_sc_pkg.sv
// Package: shared widths, operand class encoding and constant words for the
// fused multiply-add special-case resolver. Assumes binary32 layout.
package fma_sc_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int N_OPS  = 3;

    // Operand classes as seen by the resolver.
    typedef enum logic [2:0] {
        CL_ZERO   = 3'd0,
        CL_DENORM = 3'd1,
        CL_NORM   = 3'd2,
        CL_INF    = 3'd3,
        CL_QNAN   = 3'd4,
        CL_SNAN   = 3'd5
    } op_class_e;

    // Rounding mode value that selects a negative exact zero.
    localparam logic [1:0] RM_TO_NEG_INF = 2'b11;

    // Canonical quiet NaN returned by invalid operations.
    localparam logic [WORD_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // Build an infinity of the given sign.
    function automatic logic [WORD_W-1:0] make_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    // Build a zero of the given sign.
    function automatic logic [WORD_W-1:0] make_zero(input logic s);
        return {s, {(WORD_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/fma_sc_classify.sv
// Module: fma_sc_classify
// Sorts one floating-point word into zero, denormal, normal, infinity,
// quiet NaN or signalling NaN. The quiet bit is the top fraction bit.
// Purely combinational; assumes the sign is the MSB and the exponent is next.
module fma_sc_classify
    import fma_sc_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] word,
    output op_class_e      cls
);
    localparam int QBIT = FW - 1;

    logic [EW-1:0] expo;
    logic [FW-1:0] frac;
    logic          exp_ones;
    logic          exp_zeros;
    logic          frac_nz;

    // Split the word into its fields and summarise them.
    always_comb begin
        expo      = word[EW+FW-1:FW];
        frac      = word[FW-1:0];
        exp_ones  = &expo;
        exp_zeros = ~|expo;
        frac_nz   = |frac;
    end

    // Pick the class from the exponent and fraction summaries.
    always_comb begin
        if (exp_ones) begin
            if (!frac_nz)         cls = CL_INF;
            else if (frac[QBIT])  cls = CL_QNAN;
            else                  cls = CL_SNAN;
        end else if (exp_zeros) begin
            cls = frac_nz ? CL_DENORM : CL_ZERO;
        end else begin
            cls = CL_NORM;
        end
    end

endmodule

// File: rtl/fma_sc_nan_select.sv
// Module: fma_sc_nan_select
// Chooses which NaN operand, if any, sets the result. Every signalling NaN
// beats every quiet NaN; within a kind, lower index wins (index 0 = z,
// 1 = x, 2 = y). A signalling NaN is quieted and raises invalid.
module fma_sc_nan_select
    import fma_sc_pkg::*;
#(
    parameter int NOPS = N_OPS,
    parameter int WW   = WORD_W,
    parameter int FW   = FRAC_W
) (
    input  logic [NOPS-1:0][WW-1:0] words,
    input  op_class_e               cls [NOPS],
    output logic                    hit,
    output logic                    raise_inv,
    output logic [WW-1:0]           result
);
    localparam int QBIT = FW - 1;

    logic [NOPS-1:0] is_snan;
    logic [NOPS-1:0] is_qnan;

    // One detector pair per operand position.
    for (genvar g = 0; g < NOPS; g++) begin : g_det
        assign is_snan[g] = (cls[g] == CL_SNAN);
        assign is_qnan[g] = (cls[g] == CL_QNAN);
    end

    // Priority pick: scan from last to first so the lowest index wins.
    always_comb begin
        hit       = 1'b0;
        raise_inv = 1'b0;
        result    = '0;
        if (|is_snan) begin
            hit       = 1'b1;
            raise_inv = 1'b1;
            for (int i = NOPS - 1; i >= 0; i--) begin
                if (is_snan[i]) begin
                    result       = words[i];
                    result[QBIT] = 1'b1;
                end
            end
        end else if (|is_qnan) begin
            hit = 1'b1;
            for (int i = NOPS - 1; i >= 0; i--) begin
                if (is_qnan[i]) result = words[i];
            end
        end
    end

endmodule

// File: rtl/fma_sc_inf_zero.sv
// Module: fma_sc_inf_zero
// Resolves the non-NaN special cases: infinity times zero, an infinite
// product, a zero product, and a finite product against an infinite addend.
// Assumes the caller gives NaN selection higher priority.
module fma_sc_inf_zero
    import fma_sc_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  op_class_e       cls_z,
    input  op_class_e       cls_x,
    input  op_class_e       cls_y,
    input  logic [WW-1:0]   z_word,
    input  logic            p_sign,
    input  logic            a_sign,
    input  logic [1:0]      rnd_mode,
    output logic            hit,
    output logic            raise_inv,
    output logic [WW-1:0]   result
);
    logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;
    logic prod_inf, prod_zero, inf_times_zero;

    // Decode the class facts used by the rules.
    always_comb begin
        x_inf          = (cls_x == CL_INF);
        y_inf          = (cls_y == CL_INF);
        x_zero         = (cls_x == CL_ZERO);
        y_zero         = (cls_y == CL_ZERO);
        z_inf          = (cls_z == CL_INF);
        z_zero         = (cls_z == CL_ZERO);
        inf_times_zero = (x_inf && y_zero) || (x_zero && y_inf);
        prod_inf       = x_inf || y_inf;
        prod_zero      = x_zero || y_zero;
    end

    // Apply the rules in priority order.
    always_comb begin
        hit       = 1'b1;
        raise_inv = 1'b0;
        result    = '0;
        if (inf_times_zero) begin
            raise_inv = 1'b1;
            result    = CANON_NAN;
        end else if (prod_inf) begin
            if (z_inf && (a_sign != p_sign)) begin
                raise_inv = 1'b1;
                result    = CANON_NAN;
            end else begin
                result = make_inf(p_sign);
            end
        end else if (prod_zero) begin
            if (z_zero) begin
                if (a_sign == p_sign) result = make_zero(a_sign);
                else                  result = make_zero(rnd_mode == RM_TO_NEG_INF);
            end else begin
                result = {a_sign, z_word[WW-2:0]};
            end
        end else if (z_inf) begin
            result = make_inf(a_sign);
        end else begin
            hit = 1'b0;
        end
    end

endmodule

// File: rtl/fma_special_resolve.sv
// Module: fma_special_resolve (top)
// Decides whether z + x*y can be settled from the operand classes alone.
// It classifies the three operands, applies the negate controls, and merges
// the NaN selector (highest priority) with the infinity/zero resolver.
// Purely combinational; no clock or reset.
module fma_special_resolve
    import fma_sc_pkg::*;
(
    input  logic [31:0] in_z,
    input  logic [31:0] in_x,
    input  logic [31:0] in_y,
    input  logic        neg_prod,
    input  logic        neg_add,
    input  logic [1:0]  rnd_mode,
    output logic        byp_valid,
    output logic [31:0] byp_result,
    output logic        invalid,
    output logic        prod_sign,
    output logic        add_sign
);
    localparam int IDX_Z = 0;
    localparam int IDX_X = 1;
    localparam int IDX_Y = 2;

    logic [N_OPS-1:0][WORD_W-1:0] ops;
    op_class_e                    cls [N_OPS];
    logic                         nan_hit, nan_inv;
    logic [WORD_W-1:0]            nan_word;
    logic                         iz_hit, iz_inv;
    logic [WORD_W-1:0]            iz_word;

    // Gather the operands in precedence order z, x, y.
    always_comb begin
        ops[IDX_Z] = in_z;
        ops[IDX_X] = in_x;
        ops[IDX_Y] = in_y;
    end

    // One classifier per operand.
    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fma_sc_classify #(.EW(EXP_W), .FW(FRAC_W)) i_cls (
            .word (ops[g]),
            .cls  (cls[g])
        );
    end

    // Effective signs after the negate controls.
    always_comb begin
        prod_sign = in_x[WORD_W-1] ^ in_y[WORD_W-1] ^ neg_prod;
        add_sign  = in_z[WORD_W-1] ^ neg_add;
    end

    fma_sc_nan_select #(.NOPS(N_OPS), .WW(WORD_W), .FW(FRAC_W)) i_nan (
        .words     (ops),
        .cls       (cls),
        .hit       (nan_hit),
        .raise_inv (nan_inv),
        .result    (nan_word)
    );

    fma_sc_inf_zero #(.WW(WORD_W)) i_iz (
        .cls_z     (cls[IDX_Z]),
        .cls_x     (cls[IDX_X]),
        .cls_y     (cls[IDX_Y]),
        .z_word    (in_z),
        .p_sign    (prod_sign),
        .a_sign    (add_sign),
        .rnd_mode  (rnd_mode),
        .hit       (iz_hit),
        .raise_inv (iz_inv),
        .result    (iz_word)
    );

    // Merge: NaN outcome wins over the infinity/zero outcome.
    always_comb begin
        if (nan_hit) begin
            byp_valid  = 1'b1;
            byp_result = nan_word;
            invalid    = nan_inv;
        end else if (iz_hit) begin
            byp_valid  = 1'b1;
            byp_result = iz_word;
            invalid    = iz_inv;
        end else begin
            byp_valid  = 1'b0;
            byp_result = '0;
            invalid    = 1'b0;
        end
    end

endmodule

// File: rtl/fma_special_resolve_chk.sv
// Module: fma_special_resolve_chk
// Port-level checker for the resolver. The block has no clock, so every
// check is an immediate assertion evaluated whenever its inputs change.
module fma_special_resolve_chk (
    input logic [31:0] in_z,
    input logic [31:0] in_x,
    input logic [31:0] in_y,
    input logic        byp_valid,
    input logic [31:0] byp_result,
    input logic        invalid
);
    logic any_snan, any_nan, res_nan, x_inf_y_zero;

    // Summarise the port values the checks relate.
    always_comb begin
        any_snan = ((&in_z[30:23]) && !in_z[22] && (|in_z[21:0])) ||
                   ((&in_x[30:23]) && !in_x[22] && (|in_x[21:0])) ||
                   ((&in_y[30:23]) && !in_y[22] && (|in_y[21:0]));
        any_nan  = (in_z[30:0] > 31'h7F800000) || (in_x[30:0] > 31'h7F800000) ||
                   (in_y[30:0] > 31'h7F800000);
        res_nan  = (&byp_result[30:23]) && byp_result[22];
        x_inf_y_zero = (in_x[30:0] == 31'h7F800000) && (in_y[30:0] == 31'd0);
    end

    // Relations between the inputs and the outputs.
    always_comb begin
        p_invalid_needs_bypass_r12: assert (!invalid || byp_valid)
            else $error("invalid raised without bypass");
        p_invalid_gives_qnan_r12: assert (!invalid || res_nan)
            else $error("invalid raised with non-NaN result");
        p_snan_flags_r2: assert (!any_snan || (invalid && byp_valid && byp_result[22]))
            else $error("signalling NaN not flagged");
        p_nan_bypasses_r3: assert (!any_nan || (byp_valid && res_nan))
            else $error("NaN input not bypassed as NaN");
        p_idle_quiet_r11: assert (byp_valid || (byp_result == 32'd0 && !invalid))
            else $error("outputs not idle without bypass");
        p_inf_zero_invalid_r4: assert (any_nan || !x_inf_y_zero ||
                                       (invalid && byp_result == 32'h7FC00000))
            else $error("infinity times zero not invalid");
    end

endmodule

bind fma_special_resolve fma_special_resolve_chk i_chk (
    .in_z       (in_z),
    .in_x       (in_x),
    .in_y       (in_y),
    .byp_valid  (byp_valid),
    .byp_result (byp_result),
    .invalid    (invalid)
);

// File: tb/test_fma_special_resolve.sv
// Bench: sweeps every ordered triple of ten representative operands under
// all negate and rounding-mode settings and checks against a rule model.
module test_fma_special_resolve;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_z = '0, in_x = '0, in_y = '0;
    logic        neg_prod = 1'b0, neg_add = 1'b0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        byp_valid, invalid, prod_sign, add_sign;
    logic [31:0] byp_result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fma_special_resolve i_fma_special_resolve (
        .in_z(in_z), .in_x(in_x), .in_y(in_y),
        .neg_prod(neg_prod), .neg_add(neg_add), .rnd_mode(rnd_mode),
        .byp_valid(byp_valid), .byp_result(byp_result), .invalid(invalid),
        .prod_sign(prod_sign), .add_sign(add_sign)
    );

    function automatic logic [31:0] pick(input int i);
        case (i)
            0: return 32'h00000000;  // +0
            1: return 32'h80000000;  // -0
            2: return 32'h00000003;  // +denormal
            3: return 32'hBF800000;  // -1.0
            4: return 32'h40400000;  // +3.0
            5: return 32'h7F800000;  // +inf
            6: return 32'hFF800000;  // -inf
            7: return 32'h7FC12345;  // quiet NaN
            8: return 32'hFFA00001;  // -signalling NaN
            default: return 32'h7F800ABC; // signalling NaN
        endcase
    endfunction

    function automatic bit f_nan(input logic [31:0] w);  return w[30:0] > 31'h7F800000; endfunction
    function automatic bit f_snan(input logic [31:0] w); return f_nan(w) && !w[22]; endfunction
    function automatic bit f_inf(input logic [31:0] w);  return w[30:0] == 31'h7F800000; endfunction
    function automatic bit f_zero(input logic [31:0] w); return w[30:0] == 31'd0; endfunction

    // Rule model written from the requirements.
    task automatic model(input logic [31:0] z, x, y, input logic np, na, input logic [1:0] rm,
                         output logic v, output logic [31:0] r, output logic inv,
                         output string tag);
        logic ps, as;
        ps = x[31] ^ y[31] ^ np;
        as = z[31] ^ na;
        v = 1'b1; inv = 1'b0; r = 32'd0;
        if (f_snan(z))      begin r = z | 32'h00400000; inv = 1'b1; tag = "R2"; end
        else if (f_snan(x)) begin r = x | 32'h00400000; inv = 1'b1; tag = "R2"; end
        else if (f_snan(y)) begin r = y | 32'h00400000; inv = 1'b1; tag = "R2"; end
        else if (f_nan(z))  begin r = z; tag = "R3"; end
        else if (f_nan(x))  begin r = x; tag = "R3"; end
        else if (f_nan(y))  begin r = y; tag = "R3"; end
        else if ((f_inf(x) && f_zero(y)) || (f_zero(x) && f_inf(y))) begin
            r = 32'h7FC00000; inv = 1'b1; tag = "R4";
        end else if (f_inf(x) || f_inf(y)) begin
            if (f_inf(z) && as != ps) begin r = 32'h7FC00000; inv = 1'b1; tag = "R5"; end
            else begin r = ps ? 32'hFF800000 : 32'h7F800000; tag = "R6"; end
        end else if (f_zero(x) || f_zero(y)) begin
            if (!f_zero(z))      begin r = {as, z[30:0]}; tag = "R7"; end
            else if (as == ps)   begin r = {as, 31'd0}; tag = "R8"; end
            else                 begin r = {(rm == 2'b11), 31'd0}; tag = "R9"; end
        end else if (f_inf(z)) begin
            r = as ? 32'hFF800000 : 32'h7F800000; tag = "R10";
        end else begin
            v = 1'b0; tag = "R11";
        end
    endtask

    // Drive one stimulus at a falling edge and check 2 ns later.
    task automatic run_one(input logic [31:0] z, x, y, input logic np, na, input logic [1:0] rm);
        logic ev, einv;
        logic [31:0] er;
        string tag;
        @(negedge clk);
        in_z = z; in_x = x; in_y = y; neg_prod = np; neg_add = na; rnd_mode = rm;
        #2;
        model(z, x, y, np, na, rm, ev, er, einv, tag);
        n_tests++;
        if (byp_valid !== ev || byp_result !== er || invalid !== einv) begin
            n_fail++;
            $display("FAIL %s z=%h x=%h y=%h np=%0b na=%0b rm=%0d: got v=%0b r=%h inv=%0b exp v=%0b r=%h inv=%0b",
                     tag, z, x, y, np, na, rm, byp_valid, byp_result, invalid, ev, er, einv);
        end
        n_tests++;
        if (prod_sign !== (x[31] ^ y[31] ^ np) || add_sign !== (z[31] ^ na)) begin
            n_fail++;
            $display("FAIL R1 signs: got ps=%0b as=%0b exp ps=%0b as=%0b",
                     prod_sign, add_sign, x[31] ^ y[31] ^ np, z[31] ^ na);
        end
        n_tests++;
        if (invalid === 1'b1 && byp_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R12 invalid without bypass: got v=%0b exp v=1", byp_valid);
        end
    endtask

    // Watchdog: an overrun is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle start: all-zero inputs give +0 (R8).
        run_one(32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 2'b00);
        // Directed corners.
        run_one(32'h7FC00001, 32'h7F800001, 32'h7FC00002, 1'b0, 1'b0, 2'b00); // R2: sNaN x beats qNaN z
        run_one(32'h3F800000, 32'h7FC00005, 32'hFFC00006, 1'b0, 1'b0, 2'b00); // R3: x before y
        run_one(32'h3F800000, 32'h00000000, 32'hFF800000, 1'b0, 1'b0, 2'b00); // R4
        run_one(32'h7F800000, 32'h7F800000, 32'h3F800000, 1'b1, 1'b0, 2'b00); // R5
        run_one(32'h7F800000, 32'h7F800000, 32'h3F800000, 1'b0, 1'b0, 2'b00); // R6
        run_one(32'h00000005, 32'h80000000, 32'h3F800000, 1'b0, 1'b1, 2'b00); // R7 denormal z
        run_one(32'h80000000, 32'h00000000, 32'h3F800000, 1'b0, 1'b0, 2'b11); // R9 minus
        run_one(32'h80000000, 32'h00000000, 32'h3F800000, 1'b0, 1'b0, 2'b10); // R9 plus
        run_one(32'hFF800000, 32'h00000001, 32'h00000002, 1'b0, 1'b1, 2'b00); // R10
        run_one(32'h3F800000, 32'h40000000, 32'h40400000, 1'b0, 1'b0, 2'b00); // R11
        // Exhaustive sweep of the representative set.
        for (int iz = 0; iz < 10; iz++)
            for (int ix = 0; ix < 10; ix++)
                for (int iy = 0; iy < 10; iy++)
                    for (int ng = 0; ng < 4; ng++)
                        for (int rm = 0; rm < 4; rm++)
                            run_one(pick(iz), pick(ix), pick(iy), ng[1], ng[0], rm[1:0]);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule